// File: doc/BRIEF.md
# Three-Dimensional Transfer Address Generator

This block walks the byte addresses of a memory transfer laid out in three nested dimensions. The innermost unit is an array of a configured number of bytes. A configured number of arrays makes a frame, and a configured number of frames makes the whole block. The generator keeps a source and a destination address in step. Both start from their own start address. Inside an array each accepted beat moves both addresses forward by one byte. Between arrays each side jumps by its own signed array offset. Between frames each side jumps by its own signed frame offset.

A controller writes the start addresses, the three counts and the offsets, then pulses `start`. While `busy` is high the current addresses are valid. A beat is accepted on every cycle in which `beat_rdy` is high. The three end flags mark the last byte of an array, of a frame and of the block. `done` pulses once after the final beat. A start request that carries a zero count is refused with an error pulse. Data movement, bus protocol and channel arbitration are handled outside this block.

Top module: `addr3d_gen`

## Requirements
- R1: After reset, `busy`, `done` and `cfg_err` are all 0.
- R2: A `start` pulse while idle, with all three counts nonzero, sets `busy` to 1 in the next cycle, with `src_addr` equal to `src_start` and `dst_addr` equal to `dst_start`.
- R3: While busy, a cycle with `beat_rdy` high that is not the last byte of an array adds 1 to both addresses. A cycle with `beat_rdy` low leaves both addresses unchanged.
- R4: After the last byte of an array that is not the last array of its frame, each address becomes the start address of that array plus the sign-extended 16-bit array offset of its side.
- R5: After the last byte of a frame that is not the last frame, each address becomes the start address of that frame plus that side's sign-extended frame offset. In `cidx_word`, bits 15:0 hold the source frame offset and bits 31:16 hold the destination frame offset.
- R6: `end_arr` is high on the last byte of every array, `end_frm` on the last byte of the last array of a frame, and `end_blk` on the final byte of the block. All three flags are 0 while idle.
- R7: `done` is high for exactly one cycle, in the cycle after the final beat is accepted. `busy` is 0 in that cycle.
- R8: A `start` while idle with `acnt`, `bcnt` or `ccnt_word[15:0]` equal to zero produces a one-cycle `cfg_err` pulse in the next cycle, and `busy` stays 0.
- R9: Bits 31:16 of `ccnt_word` have no effect. The frame count is taken from bits 15:0 only.
- R10: All address arithmetic wraps modulo 2^32.
- R11: A `start` pulse while busy is ignored: the address sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to load the configuration and begin |
| beat_rdy | input | 1 | Accept the current beat |
| src_start | input | 32 | Source start byte address |
| dst_start | input | 32 | Destination start byte address |
| acnt | input | 16 | Bytes per array |
| bcnt | input | 16 | Arrays per frame |
| ccnt_word | input | 32 | Frame count in bits 15:0; bits 31:16 unused |
| src_bidx | input | 16 | Signed source offset between arrays |
| dst_bidx | input | 16 | Signed destination offset between arrays |
| cidx_word | input | 32 | Signed frame offsets: destination in 31:16, source in 15:0 |
| busy | output | 1 | Transfer in progress; addresses valid |
| src_addr | output | 32 | Current source byte address |
| dst_addr | output | 32 | Current destination byte address |
| end_arr | output | 1 | Current beat is the last byte of an array |
| end_frm | output | 1 | Current beat is the last byte of a frame |
| end_blk | output | 1 | Current beat is the last byte of the block |
| done | output | 1 | One-cycle pulse after the final beat |
| cfg_err | output | 1 | One-cycle pulse after a refused start |

## Verification
All outputs come either from registers or from logic fed only by registers, so every result is due one clock edge after its stimulus. A start or an accepted beat on edge N shows its new addresses, new flags, `done` or `cfg_err` at edge N. The bench drives inputs at the falling edge and samples outputs at the next falling edge, half a period after the edge that updated them. It therefore reads each beat's addresses and flags in the cycle before it accepts that beat. It reads `done` and `cfg_err` in the cycle straight after the edge that produced them, and reads them once more a cycle later to confirm each is a single pulse.

// File: rtl/addr3d_pkg.sv
package addr3d_pkg;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int IDX_W  = 16;
    localparam int NSIDE  = 2;

    typedef logic [ADDR_W-1:0]        addr_t;
    typedef logic [CNT_W-1:0]         cnt_t;
    typedef logic signed [IDX_W-1:0]  idx_t;

    // Packed pair of frame offsets: destination in the upper half.
    typedef struct packed {
        idx_t dst;
        idx_t src;
    } cidx_pair_t;

    // Frame-count word: upper half unused.
    typedef struct packed {
        logic [CNT_W-1:0] unused;
        cnt_t             frames;
    } ccnt_word_t;

    typedef struct packed {
        logic arr;
        logic frm;
        logic blk;
    } end_flags_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    function automatic addr_t add_off(addr_t base, idx_t off);
        addr_t ext;
        ext = addr_t'({{(ADDR_W-IDX_W){off[IDX_W-1]}}, off});
        return base + ext;
    endfunction

endpackage

// File: rtl/addr3d_cnt.sv
module addr3d_cnt
    import addr3d_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic step,
    input  cnt_t a_lim,
    input  cnt_t b_lim,
    input  cnt_t c_lim,
    output end_flags_t flags_raw
);
    cnt_t a_i, b_i, c_i;
    cnt_t a_max, b_max, c_max;
    logic last_a, last_b, last_c;

    assign last_a = (a_i == a_max);
    assign last_b = (b_i == b_max);
    assign last_c = (c_i == c_max);

    assign flags_raw.arr = last_a;
    assign flags_raw.frm = last_a & last_b;
    assign flags_raw.blk = last_a & last_b & last_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_i   <= '0;
            b_i   <= '0;
            c_i   <= '0;
            a_max <= '0;
            b_max <= '0;
            c_max <= '0;
        end else if (load) begin
            a_i   <= '0;
            b_i   <= '0;
            c_i   <= '0;
            a_max <= a_lim - cnt_t'(1);
            b_max <= b_lim - cnt_t'(1);
            c_max <= c_lim - cnt_t'(1);
        end else if (step) begin
            if (!last_a) begin
                a_i <= a_i + cnt_t'(1);
            end else begin
                a_i <= '0;
                if (!last_b) begin
                    b_i <= b_i + cnt_t'(1);
                end else begin
                    b_i <= '0;
                    if (!last_c) begin
                        c_i <= c_i + cnt_t'(1);
                    end else begin
                        c_i <= '0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/addr3d_side.sv
module addr3d_side
    import addr3d_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  step,
    input  logic  arr_end,
    input  logic  frm_end,
    input  addr_t start_addr,
    input  idx_t  b_off,
    input  idx_t  c_off,
    output addr_t addr
);
    addr_t cur_q, arr_base_q, frm_base_q;
    idx_t  b_q, c_q;
    addr_t next_arr, next_frm;

    assign next_arr = add_off(arr_base_q, b_q);
    assign next_frm = add_off(frm_base_q, c_q);
    assign addr     = cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q      <= '0;
            arr_base_q <= '0;
            frm_base_q <= '0;
            b_q        <= '0;
            c_q        <= '0;
        end else if (load) begin
            cur_q      <= start_addr;
            arr_base_q <= start_addr;
            frm_base_q <= start_addr;
            b_q        <= b_off;
            c_q        <= c_off;
        end else if (step) begin
            if (frm_end) begin
                frm_base_q <= next_frm;
                arr_base_q <= next_frm;
                cur_q      <= next_frm;
            end else if (arr_end) begin
                arr_base_q <= next_arr;
                cur_q      <= next_arr;
            end else begin
                cur_q <= cur_q + addr_t'(1);
            end
        end
    end
endmodule

// File: rtl/addr3d_gen.sv
module addr3d_gen
    import addr3d_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                beat_rdy,
    input  logic [ADDR_W-1:0]   src_start,
    input  logic [ADDR_W-1:0]   dst_start,
    input  logic [CNT_W-1:0]    acnt,
    input  logic [CNT_W-1:0]    bcnt,
    input  logic [2*CNT_W-1:0]  ccnt_word,
    input  logic [IDX_W-1:0]    src_bidx,
    input  logic [IDX_W-1:0]    dst_bidx,
    input  logic [2*IDX_W-1:0]  cidx_word,
    output logic                busy,
    output logic [ADDR_W-1:0]   src_addr,
    output logic [ADDR_W-1:0]   dst_addr,
    output logic                end_arr,
    output logic                end_frm,
    output logic                end_blk,
    output logic                done,
    output logic                cfg_err
);
    run_state_t state_q;
    ccnt_word_t ccw;
    cidx_pair_t cpair;
    end_flags_t raw_flags;
    logic zero_cfg, start_idle, load, beat;

    addr_t side_start [NSIDE];
    idx_t  side_b     [NSIDE];
    idx_t  side_c     [NSIDE];
    addr_t side_addr  [NSIDE];

    assign ccw   = ccnt_word_t'(ccnt_word);
    assign cpair = cidx_pair_t'(cidx_word);

    assign zero_cfg   = (acnt == '0) || (bcnt == '0) || (ccw.frames == '0);
    assign start_idle = start && (state_q == ST_IDLE);
    assign load       = start_idle && !zero_cfg;
    assign busy       = (state_q == ST_RUN);
    assign beat       = busy && beat_rdy;

    assign end_arr = busy && raw_flags.arr;
    assign end_frm = busy && raw_flags.frm;
    assign end_blk = busy && raw_flags.blk;

    addr3d_cnt u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .step      (beat),
        .a_lim     (acnt),
        .b_lim     (bcnt),
        .c_lim     (ccw.frames),
        .flags_raw (raw_flags)
    );

    assign side_start[0] = src_start;
    assign side_b[0]     = src_bidx;
    assign side_c[0]     = cpair.src;
    assign side_start[1] = dst_start;
    assign side_b[1]     = dst_bidx;
    assign side_c[1]     = cpair.dst;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        addr3d_side u_side (
            .clk        (clk),
            .rst        (rst),
            .load       (load),
            .step       (beat),
            .arr_end    (raw_flags.arr),
            .frm_end    (raw_flags.frm),
            .start_addr (side_start[s]),
            .b_off      (side_b[s]),
            .c_off      (side_c[s]),
            .addr       (side_addr[s])
        );
    end

    assign src_addr = side_addr[0];
    assign dst_addr = side_addr[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            done    <= beat && raw_flags.blk;
            cfg_err <= start_idle && zero_cfg;
            if (load) begin
                state_q <= ST_RUN;
            end else if (beat && raw_flags.blk) begin
                state_q <= ST_IDLE;
            end
        end
    end
endmodule

// File: rtl/addr3d_chk.sv
module addr3d_chk (
    input logic        clk,
    input logic        rst,
    input logic        beat_rdy,
    input logic        busy,
    input logic [31:0] src_addr,
    input logic [31:0] dst_addr,
    input logic        end_arr,
    input logic        end_frm,
    input logic        end_blk,
    input logic        done,
    input logic        cfg_err
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (busy && beat_rdy && end_blk) |=> (done && !busy)); // R7
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !busy); // R8
    AST_FRM_NEST: assert property (@(posedge clk) disable iff (rst)
        end_frm |-> end_arr); // R6
    AST_BLK_NEST: assert property (@(posedge clk) disable iff (rst)
        end_blk |-> end_frm); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !end_arr); // R6
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !beat_rdy) |=> ($stable(src_addr) && $stable(dst_addr))); // R3
    AST_BYTE_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && beat_rdy && !end_arr) |=>
            (src_addr == $past(src_addr) + 32'd1 && dst_addr == $past(dst_addr) + 32'd1)); // R3
endmodule

bind addr3d_gen addr3d_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .beat_rdy (beat_rdy),
    .busy     (busy),
    .src_addr (src_addr),
    .dst_addr (dst_addr),
    .end_arr  (end_arr),
    .end_frm  (end_frm),
    .end_blk  (end_blk),
    .done     (done),
    .cfg_err  (cfg_err)
);

// File: tb/addr3d_gen_tb.sv
module addr3d_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        beat_rdy = 1'b0;
    logic [31:0] src_start = '0, dst_start = '0;
    logic [15:0] acnt = '0, bcnt = '0;
    logic [31:0] ccnt_word = '0;
    logic [15:0] src_bidx = '0, dst_bidx = '0;
    logic [31:0] cidx_word = '0;
    logic        busy, end_arr, end_frm, end_blk, done, cfg_err;
    logic [31:0] src_addr, dst_addr;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    addr3d_gen dut_i (
        .clk(clk), .rst(rst), .start(start), .beat_rdy(beat_rdy),
        .src_start(src_start), .dst_start(dst_start),
        .acnt(acnt), .bcnt(bcnt), .ccnt_word(ccnt_word),
        .src_bidx(src_bidx), .dst_bidx(dst_bidx), .cidx_word(cidx_word),
        .busy(busy), .src_addr(src_addr), .dst_addr(dst_addr),
        .end_arr(end_arr), .end_frm(end_frm), .end_blk(end_blk),
        .done(done), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    // Full transfer with expected addresses computed arithmetically.
    task automatic run_xfer(input logic [31:0] s0, input logic [31:0] d0,
                            input int na, input int nb, input int nc,
                            input logic [15:0] bs, input logic [15:0] bd,
                            input logic [15:0] cs, input logic [15:0] cd,
                            input bit stall, input bit restart_mid);
        int n = 0;
        @(negedge clk);
        src_start = s0; dst_start = d0;
        acnt = 16'(na); bcnt = 16'(nb);
        ccnt_word = {16'hA5C3, 16'(nc)};          // R9: upper half junk
        src_bidx = bs; dst_bidx = bd;
        cidx_word = {cd, cs};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", 32'(busy), 32'd1);
        for (int c = 0; c < nc; c++) begin
            for (int b = 0; b < nb; b++) begin
                for (int a = 0; a < na; a++) begin
                    logic [31:0] es, ed;
                    string rq;
                    es = s0 + 32'(c) * sx(cs) + 32'(b) * sx(bs) + 32'(a);
                    ed = d0 + 32'(c) * sx(cd) + 32'(b) * sx(bd) + 32'(a);
                    if (n == 0) rq = "R2";
                    else if (a > 0) rq = "R3";
                    else if (b > 0) rq = "R4";
                    else rq = "R5";
                    if (stall && (n % 3 == 1)) begin
                        beat_rdy = 1'b0;
                        @(negedge clk);
                        chk(src_addr == es, "R3", "src held in stall", src_addr, es);
                    end
                    chk(src_addr == es, rq, "src addr", src_addr, es);
                    chk(dst_addr == ed, rq, "dst addr", dst_addr, ed);
                    chk({end_arr, end_frm, end_blk} ==
                        {a == na-1, (a == na-1) && (b == nb-1),
                         (a == na-1) && (b == nb-1) && (c == nc-1)},
                        "R6", "end flags", {29'd0, end_arr, end_frm, end_blk},
                        {29'd0, 1'(a == na-1), 1'((a == na-1) && (b == nb-1)),
                         1'((a == na-1) && (b == nb-1) && (c == nc-1))});
                    chk(done == 1'b0, "R7", "done low mid-transfer", 32'(done), 32'd0);
                    if (restart_mid && n == 1) begin
                        start = 1'b1;                 // R11: must be ignored
                        src_start = 32'h0BAD_0000; dst_start = 32'h0BAD_1000;
                    end
                    beat_rdy = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                    n++;
                end
            end
        end
        beat_rdy = 1'b0;
        chk(done == 1'b1, "R7", "done after last beat", 32'(done), 32'd1);
        chk(busy == 1'b0, "R7", "busy low after last", 32'(busy), 32'd0);
        chk(end_arr == 1'b0, "R6", "flags idle", 32'(end_arr), 32'd0);
        @(negedge clk);
        chk(done == 1'b0, "R7", "done single cycle", 32'(done), 32'd0);
    endtask

    task automatic zero_try(input int na, input int nb, input logic [31:0] cw);
        @(negedge clk);
        acnt = 16'(na); bcnt = 16'(nb); ccnt_word = cw;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cfg_err == 1'b1, "R8", "cfg_err pulse", 32'(cfg_err), 32'd1);
        chk(busy == 1'b0, "R8", "no start on zero", 32'(busy), 32'd0);
        @(negedge clk);
        chk(cfg_err == 1'b0, "R8", "cfg_err single", 32'(cfg_err), 32'd0);
        chk(busy == 1'b0, "R8", "still idle", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({busy, done, cfg_err} == 3'b000, "R1", "reset state",
            {29'd0, busy, done, cfg_err}, 32'd0);

        // Sweep every small shape with mixed-sign offsets.
        for (int na = 1; na <= 3; na++)
            for (int nb = 1; nb <= 3; nb++)
                for (int nc = 1; nc <= 3; nc++)
                    run_xfer(32'h1000_0000 + 32'(na * 256), 32'h2000_0040,
                             na, nb, nc, 16'd16, 16'hFFF0, 16'hFF00, 16'd300,
                             ((na + nb + nc) % 2) == 1, 1'b0);

        // R10: wrap across 2^32 with negative offsets wrapping below zero.
        run_xfer(32'hFFFF_FFFE, 32'h0000_0001, 3, 2, 2,
                 16'd4, 16'h8000, 16'h7FFF, 16'hFFFF, 1'b0, 1'b0);
        // R5: extreme frame offsets, each side distinct.
        run_xfer(32'h8000_0000, 32'h0000_8000, 2, 2, 3,
                 16'h0000, 16'h0001, 16'h8000, 16'h7FFF, 1'b1, 1'b0);
        // R11: start pulse during a transfer is ignored.
        run_xfer(32'h0000_4000, 32'h0000_5000, 2, 2, 2,
                 16'd8, 16'd8, 16'd64, 16'd64, 1'b0, 1'b1);

        // R8: each zero count refused; R9: upper bits do not rescue a zero.
        zero_try(0, 2, 32'd2);
        zero_try(2, 0, 32'd2);
        zero_try(2, 2, 32'hFFFF_0000);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule